// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which pending DMA channel request is started next. Each channel has five inputs: a request, an enable, a 4-bit priority, a bit that lets it be suspended by a more urgent channel, and a bit that stops it from suspending others. A run-time mode input chooses between two policies. In the first, the highest numeric priority wins. In the second, channels take turns and priority plays no part. The block keeps track of the one channel that is executing. It drops that channel when the data engine signals completion. While the channel runs, a more urgent request may take over, and the block reports this with a suspend pulse.

Three conditions stop new channel starts but leave a running channel alone. The first is a global halt input. The second is a debug stall input. The third is a latched halt that an error sets while halt-on-error is enabled; a clear pulse releases it. As a separate output, the block flags a configuration error whenever two enabled channels hold the same priority.

Top module: `dma_req_arbiter`

## Requirements
- R1: With `rr_mode_i`=0 and no channel active, the enabled requester with the highest numeric priority is granted. If priorities are equal, the lowest channel index wins. `grant_valid_o` pulses one cycle after the request is sampled, and `grant_idx_o` carries the channel.
- R2: With `rr_mode_i`=1 and no channel active, the search begins at the channel after the last one granted and wraps past the top index. Priority is ignored. After reset the search begins at channel 0.
- R3: A channel whose `ch_en_i` bit is 0 is never granted, whatever its request or priority.
- R4: After reset no channel is active and every output is 0. A grant without suspend happens only when no channel is active. A grant sets `active_o` and `active_idx_o` to the granted channel in the same cycle as the grant pulse.
- R5: While a channel is active, `done_i` clears `active_o` at the next edge, and no grant is made in that cycle. While no channel is active, `done_i` has no effect.
- R6: Preemption needs all of the following: fixed mode is selected, a channel is active, `done_i` is low, and the active channel's `ch_yield_ok_i` bit is 1. Among the enabled requesters other than the active channel whose `ch_no_preempt_i` bit is 0, the best one is chosen by the R1 rule. If its priority is strictly higher than the active channel's, it is granted and becomes active. In that same cycle `suspend_o` pulses, and `suspend_idx_o` gives the channel that was displaced.
- R7: There is no preemption in round-robin mode, nor when the active channel's `ch_yield_ok_i` is 0. A requester whose `ch_no_preempt_i` is 1 never displaces another channel.
- R8: While `halt_i` or `dbg_stall_i` is 1, no grant and no preemption happens. An active channel stays active and still accepts `done_i`.
- R9: When `err_i` and `halt_on_err_i` are both 1, `err_halt_o` is set at the next edge. It blocks grants in the same way as R8 until a `halt_clr_i` pulse clears it. If set and clear arrive together, set wins.
- R10: `prio_err_o` is 1 in the cycle after any two channels with `ch_en_i`=1 share a priority value. Channels that are disabled are left out of the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rr_mode_i | input | 1 | 0 selects fixed priority, 1 selects round robin |
| ch_req_i | input | NUM_CH | Per-channel service request |
| ch_en_i | input | NUM_CH | Per-channel request enable |
| ch_prio_i | input | NUM_CH*PRIO_W | Channel priorities, channel i at bits [i*PRIO_W +: PRIO_W] |
| ch_yield_ok_i | input | NUM_CH | Channel may be suspended by a more urgent one |
| ch_no_preempt_i | input | NUM_CH | Channel may not suspend a less urgent one |
| halt_i | input | 1 | Global halt of new starts |
| dbg_stall_i | input | 1 | Debug stall of new starts |
| halt_on_err_i | input | 1 | Errors latch a halt |
| err_i | input | 1 | Error report |
| halt_clr_i | input | 1 | Clears the latched error halt |
| done_i | input | 1 | Active channel has completed |
| grant_valid_o | output | 1 | One-cycle grant pulse |
| grant_idx_o | output | log2(NUM_CH) | Granted channel |
| active_o | output | 1 | A channel is executing |
| active_idx_o | output | log2(NUM_CH) | Executing channel |
| suspend_o | output | 1 | One-cycle preemption pulse |
| suspend_idx_o | output | log2(NUM_CH) | Channel that was displaced |
| err_halt_o | output | 1 | Latched error halt |
| prio_err_o | output | 1 | Enabled channels share a priority |

## Verification
The assertions assume that inputs settle between clock edges and are held through each rising edge. They also assume that `done_i` refers only to the channel reported on `active_idx_o`. The bench drives every input one time unit after the rising edge. It raises `done_i` as a plain per-cycle level, which the arbiter ignores while idle. Priority vectors are mostly distinct, and sharing is introduced on purpose only where the priority-error flag and the tie rule are being exercised.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int unsigned DEF_NUM_CH = 16;
    localparam int unsigned DEF_PRIO_W = 4;

    typedef enum logic {
        ARB_FIXED = 1'b0,
        ARB_ROUND = 1'b1
    } arb_mode_e;
endpackage

// File: rtl/dma_arb_prio_pick.sv
module dma_arb_prio_pick #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned PRIO_W = 4,
    localparam int unsigned IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0]        cand_i,
    input  logic [NUM_CH*PRIO_W-1:0] prio_i,
    output logic                     found_o,
    output logic [IW-1:0]            idx_o,
    output logic [PRIO_W-1:0]        prio_o
);
    // strict compare keeps the lowest index on equal priority
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cand_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
                prio_o  = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
    parameter int unsigned NUM_CH = 16,
    localparam int unsigned IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] cand_i,
    input  logic [IW-1:0]     last_i,
    output logic              found_o,
    output logic [IW-1:0]     idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = 1; k <= NUM_CH; k++) begin
            int c;
            c = (int'(last_i) + k) % NUM_CH;
            if (!found_o && cand_i[c]) begin
                found_o = 1'b1;
                idx_o   = IW'(c);
            end
        end
    end
endmodule

// File: rtl/dma_arb_dup_check.sv
module dma_arb_dup_check #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned PRIO_W = 4
) (
    input  logic [NUM_CH-1:0]        en_i,
    input  logic [NUM_CH*PRIO_W-1:0] prio_i,
    output logic                     dup_o
);
    logic [NUM_CH-1:0] row_hit;

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_row
        always_comb begin
            row_hit[gi] = 1'b0;
            for (int j = gi + 1; j < NUM_CH; j++) begin
                if (en_i[gi] && en_i[j] &&
                    prio_i[gi*PRIO_W +: PRIO_W] == prio_i[j*PRIO_W +: PRIO_W])
                    row_hit[gi] = 1'b1;
            end
        end
    end

    assign dup_o = |row_hit;
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_NUM_CH,
    parameter int unsigned PRIO_W = DEF_PRIO_W,
    localparam int unsigned IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rr_mode_i,
    input  logic [NUM_CH-1:0]        ch_req_i,
    input  logic [NUM_CH-1:0]        ch_en_i,
    input  logic [NUM_CH*PRIO_W-1:0] ch_prio_i,
    input  logic [NUM_CH-1:0]        ch_yield_ok_i,
    input  logic [NUM_CH-1:0]        ch_no_preempt_i,
    input  logic                     halt_i,
    input  logic                     dbg_stall_i,
    input  logic                     halt_on_err_i,
    input  logic                     err_i,
    input  logic                     halt_clr_i,
    input  logic                     done_i,
    output logic                     grant_valid_o,
    output logic [IW-1:0]            grant_idx_o,
    output logic                     active_o,
    output logic [IW-1:0]            active_idx_o,
    output logic                     suspend_o,
    output logic [IW-1:0]            suspend_idx_o,
    output logic                     err_halt_o,
    output logic                     prio_err_o
);
    typedef struct packed {
        logic          active;
        logic [IW-1:0] aidx;
        logic [IW-1:0] last;
        logic          gv;
        logic [IW-1:0] gidx;
        logic          susp;
        logic [IW-1:0] sidx;
        logic          ehalt;
        logic          perr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    arb_mode_e mode;
    assign mode = arb_mode_e'(rr_mode_i);

    logic [NUM_CH-1:0] cand, pre_cand;
    logic              fx_found, rr_found, pr_found, dup;
    logic [IW-1:0]     fx_idx, rr_idx, pr_idx;
    logic [PRIO_W-1:0] fx_prio, pr_prio, act_prio;
    logic              blocked;

    assign cand     = ch_req_i & ch_en_i;
    assign pre_cand = cand & ~ch_no_preempt_i & ~(NUM_CH'(1) << st_q.aidx);
    assign act_prio = ch_prio_i[st_q.aidx*PRIO_W +: PRIO_W];
    assign blocked  = halt_i | dbg_stall_i | st_q.ehalt;

    dma_arb_prio_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_fixed (
        .cand_i(cand), .prio_i(ch_prio_i),
        .found_o(fx_found), .idx_o(fx_idx), .prio_o(fx_prio)
    );

    dma_arb_prio_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_preempt (
        .cand_i(pre_cand), .prio_i(ch_prio_i),
        .found_o(pr_found), .idx_o(pr_idx), .prio_o(pr_prio)
    );

    dma_arb_rr_pick #(.NUM_CH(NUM_CH)) u_round (
        .cand_i(cand), .last_i(st_q.last),
        .found_o(rr_found), .idx_o(rr_idx)
    );

    dma_arb_dup_check #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_dup (
        .en_i(ch_en_i), .prio_i(ch_prio_i), .dup_o(dup)
    );

    always_comb begin
        st_d      = st_q;
        st_d.gv   = 1'b0;
        st_d.susp = 1'b0;
        st_d.perr = dup;

        if (err_i && halt_on_err_i)
            st_d.ehalt = 1'b1;
        else if (halt_clr_i)
            st_d.ehalt = 1'b0;

        if (st_q.active && done_i)
            st_d.active = 1'b0;

        if (!blocked) begin
            if (!st_q.active) begin
                if (mode == ARB_ROUND && rr_found) begin
                    st_d.gv   = 1'b1;
                    st_d.gidx = rr_idx;
                end else if (mode == ARB_FIXED && fx_found) begin
                    st_d.gv   = 1'b1;
                    st_d.gidx = fx_idx;
                end
            end else if (mode == ARB_FIXED && !done_i &&
                         ch_yield_ok_i[st_q.aidx] && pr_found && pr_prio > act_prio) begin
                st_d.gv   = 1'b1;
                st_d.gidx = pr_idx;
                st_d.susp = 1'b1;
                st_d.sidx = st_q.aidx;
            end
        end

        if (st_d.gv) begin
            st_d.active = 1'b1;
            st_d.aidx   = st_d.gidx;
            st_d.last   = st_d.gidx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.last <= IW'(NUM_CH - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_valid_o = st_q.gv;
    assign grant_idx_o   = st_q.gidx;
    assign active_o      = st_q.active;
    assign active_idx_o  = st_q.aidx;
    assign suspend_o     = st_q.susp;
    assign suspend_idx_o = st_q.sidx;
    assign err_halt_o    = st_q.ehalt;
    assign prio_err_o    = st_q.perr;

    AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> ((($past(ch_req_i & ch_en_i)) >> grant_idx_o) & NUM_CH'(1)) != '0); // R3
    AST_GRANT_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> (active_o && active_idx_o == grant_idx_o)); // R4
    AST_PLAIN_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && !suspend_o) |-> !$past(active_o)); // R4
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && done_i) |=> !grant_valid_o); // R5
    AST_SUSPEND_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_o |-> (grant_valid_o && $past(active_o) && $past(active_idx_o) == suspend_idx_o)); // R6
    AST_NO_RR_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_o |-> !$past(rr_mode_i)); // R7
    AST_YIELD_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_o |-> ((($past(ch_yield_ok_i)) >> suspend_idx_o) & NUM_CH'(1)) != '0); // R7
    AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i || dbg_stall_i) |=> !grant_valid_o); // R8
    AST_ERR_HALT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && halt_on_err_i) |=> err_halt_o); // R9
    AST_ERR_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        err_halt_o |=> !grant_valid_o); // R9
endmodule

// File: tb/sim_dma_req_arbiter.sv
module sim_dma_req_arbiter;
    localparam int N  = 16;
    localparam int PW = 4;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          rr_mode = 0, halt = 0, dbg = 0, hoe = 0, err = 0, hclr = 0, done = 0;
    logic [N-1:0]  req = '0, en = '0, yok = '0, nopre = '0;
    logic [PW-1:0] pr [N];
    logic [N*PW-1:0] prio_flat;

    logic          gv, act, susp, eh, perr;
    logic [IW-1:0] gidx, aidx, sidx;

    always_comb
        for (int i = 0; i < N; i++) prio_flat[i*PW +: PW] = pr[i];

    dma_req_arbiter #(.NUM_CH(N), .PRIO_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .rr_mode_i(rr_mode),
        .ch_req_i(req), .ch_en_i(en), .ch_prio_i(prio_flat),
        .ch_yield_ok_i(yok), .ch_no_preempt_i(nopre),
        .halt_i(halt), .dbg_stall_i(dbg), .halt_on_err_i(hoe), .err_i(err),
        .halt_clr_i(hclr), .done_i(done),
        .grant_valid_o(gv), .grant_idx_o(gidx), .active_o(act), .active_idx_o(aidx),
        .suspend_o(susp), .suspend_idx_o(sidx), .err_halt_o(eh), .prio_err_o(perr)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // reference state
    int m_act = 0, m_aidx = 0, m_last = N - 1, m_eh = 0;
    int e_gv = 0, e_gidx = 0, e_susp = 0, e_sidx = 0, e_perr = 0;

    task automatic check(input bit ok, input string tag, input string what, input int a, input int e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, a, e);
        end
    endtask

    task automatic compare(input string tag);
        check(gv == e_gv[0], tag, "grant_valid", gv, e_gv);
        if (e_gv != 0) check(gidx == e_gidx[IW-1:0], tag, "grant_idx", gidx, e_gidx);
        check(susp == e_susp[0], tag, "suspend", susp, e_susp);
        if (e_susp != 0) check(sidx == e_sidx[IW-1:0], tag, "suspend_idx", sidx, e_sidx);
        check(act == m_act[0], tag, "active", act, m_act);
        if (m_act != 0) check(aidx == m_aidx[IW-1:0], tag, "active_idx", aidx, m_aidx);
        check(eh == m_eh[0], tag, "err_halt", eh, m_eh);
        check(perr == e_perr[0], tag, "prio_err", perr, e_perr);
    endtask

    // one clock: predict from current inputs, clock, compare
    task automatic step(input string tag);
        int n_gv, n_gidx, n_susp, n_sidx, n_act, n_aidx, n_eh, n_perr;
        bit blk;
        n_gv = 0; n_gidx = e_gidx; n_susp = 0; n_sidx = e_sidx;
        n_act = m_act; n_aidx = m_aidx; n_eh = m_eh; n_perr = 0;
        for (int i = 0; i < N; i++)
            for (int j = i + 1; j < N; j++)
                if (en[i] && en[j] && pr[i] == pr[j]) n_perr = 1;
        if (err && hoe) n_eh = 1; else if (hclr) n_eh = 0;
        if (m_act != 0 && done) n_act = 0;
        blk = halt || dbg || (m_eh != 0);
        if (!blk) begin
            if (m_act == 0) begin
                if (rr_mode) begin
                    for (int k = 1; k <= N; k++) begin
                        int c;
                        c = (m_last + k) % N;
                        if (n_gv == 0 && req[c] && en[c]) begin n_gv = 1; n_gidx = c; end
                    end
                end else begin
                    int best;
                    best = -1;
                    for (int i = 0; i < N; i++)
                        if (req[i] && en[i] && (best < 0 || int'(pr[i]) > best)) begin
                            best = pr[i]; n_gv = 1; n_gidx = i;
                        end
                end
            end else if (!rr_mode && !done && yok[m_aidx]) begin
                int best, bi;
                best = -1; bi = 0;
                for (int i = 0; i < N; i++)
                    if (i != m_aidx && req[i] && en[i] && !nopre[i] &&
                        (best < 0 || int'(pr[i]) > best)) begin
                        best = pr[i]; bi = i;
                    end
                if (best > int'(pr[m_aidx])) begin
                    n_gv = 1; n_gidx = bi; n_susp = 1; n_sidx = m_aidx;
                end
            end
        end
        if (n_gv != 0) begin n_act = 1; n_aidx = n_gidx; m_last = n_gidx; end
        @(posedge clk);
        #1;
        e_gv = n_gv; e_gidx = n_gidx; e_susp = n_susp; e_sidx = n_sidx;
        m_act = n_act; m_aidx = n_aidx; m_eh = n_eh; e_perr = n_perr;
        compare(tag);
    endtask

    task automatic quiet();
        req = '0; done = 0; halt = 0; dbg = 0; err = 0; hclr = 0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) pr[i] = PW'((i * 7) % N);
        repeat (3) @(posedge clk);
        #1;
        compare("R4");   // reset state
        rst_n = 1'b1;

        // R1: fixed priority winners, done releases each
        en = '1; yok = '0; nopre = '0;
        req = 16'h1088;       // ch3 p5, ch7 p1, ch12 p4 -> ch3
        step("R1");
        done = 1; step("R5");
        done = 0; req = 16'h1080; step("R1");
        done = 1; req = '0; step("R5");
        done = 1; step("R5");  // done while idle ignored
        done = 0;
        // tie: ch1 and ch4 share priority 7 -> lowest index
        pr[4] = 4'd7; req = 16'h0012; step("R1");
        done = 1; req = '0; step("R10");
        done = 0; en = 16'hFFEF; step("R10");  // ch4 disabled, no dup
        en = '1; pr[4] = 4'd12;

        // R2: round robin rotation with wrap
        rr_mode = 1; req = 16'h8421;
        for (int k = 0; k < 6; k++) begin
            done = 0; step("R2");
            done = 1; step("R2");
        end
        done = 0;

        // R3: disabled requesters
        req = '1; en = 16'h0100;
        step("R3"); done = 1; step("R3"); done = 0;
        rr_mode = 0; en = 16'h0200; step("R3"); done = 1; step("R3");
        en = 16'h0000; done = 0; step("R3"); step("R3");
        en = '1; quiet();

        // R4: active blocks plain grant
        req = 16'h0001; step("R4");          // ch0 p0 active
        req = 16'h0003; step("R4"); step("R4");

        // R6: preemption allowed
        yok = '1; nopre = '0;
        req = 16'h0009; step("R6");          // ch3 p5 displaces ch0
        step("R6");
        // R7: higher requester forbidden to preempt
        nopre = 16'h0004; req = 16'h000D; step("R7"); // ch2 p14 barred
        yok = 16'hFFF7; nopre = '0; step("R7");       // ch3 cannot yield
        yok = '1; rr_mode = 1; step("R7");            // rr mode
        rr_mode = 0; done = 1; step("R5"); done = 0;
        quiet();

        // R8: halt and debug stall
        req = 16'h0010; halt = 1; step("R8"); step("R8");
        halt = 0; dbg = 1; step("R8");
        dbg = 0; step("R8");
        halt = 1; done = 1; step("R8");
        halt = 0; done = 0; req = '0; step("R8");

        // R9: halt on error
        hoe = 1; err = 1; req = 16'h0100; step("R9");
        err = 0; step("R9"); step("R9");
        err = 1; hclr = 1; step("R9");       // set wins
        err = 0; step("R9");                 // clear
        hclr = 0; step("R9");
        done = 1; step("R9"); done = 0;
        hoe = 0; err = 1; step("R9"); err = 0;
        quiet();

        // mixed random traffic
        for (int c = 0; c < 600; c++) begin
            req   = 16'($urandom);
            en    = 16'($urandom) | 16'hF0F0;
            yok   = 16'($urandom);
            nopre = 16'($urandom) & 16'h1111;
            done  = ($urandom % 4) == 0;
            halt  = ($urandom % 16) == 0;
            dbg   = ($urandom % 16) == 0;
            hoe   = ($urandom % 2) == 0;
            err   = ($urandom % 32) == 0;
            hclr  = ($urandom % 8) == 0;
            if (c % 100 == 0) rr_mode = ~rr_mode;
            if (c % 50 == 0) pr[$urandom % N] = PW'($urandom);
            step(rr_mode ? "R2" : "R6");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule